// File: doc/BRIEF.md
# Peripheral Interrupt Register Set

This block keeps the interrupt bookkeeping for a group of sixteen peripheral sources, split into two 8-bit banks (A and B). Each bank has an enable, a pending, an in-service and a mask register. A vector register and two general-purpose port registers (edge and direction) sit beside them. All of them are reached through a byte-wide register access port that answers every access after a fixed number of wait states.

A source pulse latches its pending bit when the source is enabled. Software removes pending or in-service bits by writing zeros to them, while ones leave bits untouched. Clearing an enable bit also drops that source's pending bit. The request output is high whenever any pending bit is also unmasked in either bank. A simple fixed-priority pick reports which source wins. An acknowledge pulse moves that winning source from pending to in-service.

The vector, edge and direction registers are only stored. They drive no logic in this block.

Top module: `irq_reg_set`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0 and `irq` is low.
- R2: A write to an enable register (offset 0 for bank A, offset 1 for bank B) stores the data and ANDs that bank's pending register with it in the same cycle. Pending bits never exist without their enable bit.
- R3: A write to a pending register (offset 2 for A, offset 3 for B) ANDs it with the data. Zero bits clear, and one bits never set anything.
- R4: A write to an in-service register (offset 4 for A, offset 5 for B) ANDs it with the data.
- R5: Mask registers sit at offset 6 (A) and offset 7 (B). `irq` is the OR over both banks of pending AND mask, and it follows a mask write from the cycle after that write commits.
- R6: A source pulse on `src_a`/`src_b` sets its pending bit only when its enable bit is 1. The enable value used is the one written in the same cycle, if any. A set wins over a same-cycle clear of the same bit.
- R7: An access held on `bus_req` is answered by a one-cycle `bus_ack`, WAIT_STATES cycles after the request is taken. A write commits at the clock edge that ends the `bus_ack` cycle, and read data is valid while `bus_ack` is high.
- R8: Reads of unmapped offsets 11 to 15 return 0xFF.
- R9: The vector (offset 8), edge (offset 9) and direction (offset 10) registers store written data, read it back, and have no effect on `irq`.
- R10: `irq_src` is {bank_is_A, bit index} of the winning unmasked pending source. Bank A beats bank B, and within a bank the higher bit wins.
- R11: An `iack` pulse while `irq` is high clears the winning pending bit and sets the same bit in that bank's in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Access completion strobe |
| src_a | input | 8 | Source event pulses, bank A |
| src_b | input | 8 | Source event pulses, bank B |
| iack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| irq_src | output | 4 | Winning source code |

## Verification
The bench builds the block with its defaults: 8-bit banks and four wait states. With four wait states, source pulses and acknowledges can land inside an open access, so same-cycle collisions between a clear write and a set are reached. Full 8-bit banks make all sixteen priority codes and both bank orderings reachable. A long random phase mixes accesses to every offset, including the unmapped ones.

// File: rtl/irq_regs_pkg.sv
// Shared offsets for the interrupt register set. Offsets are fixed by the
// software-visible map; the register width is a parameter of the modules.
package irq_regs_pkg;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] OFF_EN_A   = 4'd0;
    localparam logic [ADDR_W-1:0] OFF_EN_B   = 4'd1;
    localparam logic [ADDR_W-1:0] OFF_PEND_A = 4'd2;
    localparam logic [ADDR_W-1:0] OFF_PEND_B = 4'd3;
    localparam logic [ADDR_W-1:0] OFF_ISR_A  = 4'd4;
    localparam logic [ADDR_W-1:0] OFF_ISR_B  = 4'd5;
    localparam logic [ADDR_W-1:0] OFF_MASK_A = 4'd6;
    localparam logic [ADDR_W-1:0] OFF_MASK_B = 4'd7;
    localparam logic [ADDR_W-1:0] OFF_VEC    = 4'd8;
    localparam logic [ADDR_W-1:0] OFF_EDGE   = 4'd9;
    localparam logic [ADDR_W-1:0] OFF_DIR    = 4'd10;
endpackage

// File: rtl/irq_bus_seq.sv
// Access sequencer: takes a held request, counts WAIT_STATES cycles, then
// raises a one-cycle acknowledge. Assumes the requester drops bus_req in
// the cycle it sees the acknowledge. WAIT_STATES must be at least 1.
module irq_bus_seq #(
    parameter int WAIT_STATES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ack
);
    localparam int CW = $clog2(WAIT_STATES + 1);

    logic          busy;
    logic [CW-1:0] cnt;

    assign ack = busy && (cnt == CW'(WAIT_STATES));

    // Busy flag and wait counter for the access in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (ack) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end else if (req) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    assert_ack_after_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(busy));
endmodule

// File: rtl/irq_bank.sv
// One bank of enable, pending, in-service and mask registers. Writes to
// pending and in-service AND the data in; an enable write also ANDs
// pending. Source sets are applied after clears, so a set wins. Assumes
// at most one write strobe per cycle and a one-hot-or-zero iack_hit.
module irq_bank #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_pend,
    input  logic          wr_isr,
    input  logic          wr_mask,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] src,
    input  logic [DW-1:0] iack_hit,
    output logic [DW-1:0] en,
    output logic [DW-1:0] pend,
    output logic [DW-1:0] isr,
    output logic [DW-1:0] mask,
    output logic [DW-1:0] active
);
    logic [DW-1:0] en_next;
    logic [DW-1:0] clr_keep;

    // Next enable value and the keep-mask applied to pending.
    always_comb begin
        en_next  = wr_en ? wdata : en;
        clr_keep = (wr_en || wr_pend) ? wdata : '1;
    end

    // Register update for the bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= '0;
            pend <= '0;
            isr  <= '0;
            mask <= '0;
        end else begin
            en   <= en_next;
            pend <= (pend & clr_keep & ~iack_hit) | (src & en_next);
            isr  <= (wr_isr ? (isr & wdata) : isr) | iack_hit;
            if (wr_mask) mask <= wdata;
        end
    end

    assign active = pend & mask;

    assert_pend_within_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & ~en) == '0);
    assert_pend_write_noset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend && src == '0) |=> ((pend & ~$past(pend)) == '0));
    assert_iack_to_isr_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_hit != '0) |=> ((isr & $past(iack_hit)) == $past(iack_hit)));
endmodule

// File: rtl/irq_prio.sv
// Fixed-priority pick over two banks: bank A beats bank B, higher bit
// wins within a bank. Purely combinational.
module irq_prio #(
    parameter int DW = 8
) (
    input  logic [DW-1:0]       act_a,
    input  logic [DW-1:0]       act_b,
    output logic                any,
    output logic [$clog2(DW):0] code,
    output logic [DW-1:0]       hit_a,
    output logic [DW-1:0]       hit_b
);
    localparam int IW = $clog2(DW);

    logic [IW-1:0] idx_a, idx_b;

    // Highest set bit in each bank; later iterations override earlier.
    always_comb begin
        idx_a = '0;
        idx_b = '0;
        for (int i = 0; i < DW; i++) begin
            if (act_a[i]) idx_a = IW'(i);
            if (act_b[i]) idx_b = IW'(i);
        end
    end

    // Bank choice, code and one-hot winner.
    always_comb begin
        any   = (|act_a) || (|act_b);
        hit_a = '0;
        hit_b = '0;
        if (|act_a) begin
            code         = {1'b1, idx_a};
            hit_a[idx_a] = 1'b1;
        end else begin
            code = {1'b0, idx_b};
            if (|act_b) hit_b[idx_b] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_reg_set.sv
// Top of the interrupt register set: access sequencer, address decode,
// two banks, priority pick and read mux. Assumes one access at a time.
module irq_reg_set
    import irq_regs_pkg::*;
#(
    parameter int DW          = 8,
    parameter int WAIT_STATES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    output logic                 bus_ack,
    input  logic [DW-1:0]        src_a,
    input  logic [DW-1:0]        src_b,
    input  logic                 iack,
    output logic                 irq,
    output logic [$clog2(DW):0]  irq_src
);
    logic          wr;
    logic [DW-1:0] en_a, pend_a, isr_a, mask_a, act_a;
    logic [DW-1:0] en_b, pend_b, isr_b, mask_b, act_b;
    logic [DW-1:0] hit_a, hit_b;
    logic [DW-1:0] vec_r, edge_r, dir_r;

    irq_bus_seq #(.WAIT_STATES(WAIT_STATES)) u_seq (
        .clk(clk), .rst_n(rst_n), .req(bus_req), .ack(bus_ack));

    assign wr = bus_ack && bus_wr;

    irq_bank #(.DW(DW)) u_bank_a (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr && bus_addr == OFF_EN_A), .wr_pend(wr && bus_addr == OFF_PEND_A),
        .wr_isr(wr && bus_addr == OFF_ISR_A), .wr_mask(wr && bus_addr == OFF_MASK_A),
        .wdata(bus_wdata), .src(src_a), .iack_hit(iack ? hit_a : '0),
        .en(en_a), .pend(pend_a), .isr(isr_a), .mask(mask_a), .active(act_a));

    irq_bank #(.DW(DW)) u_bank_b (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr && bus_addr == OFF_EN_B), .wr_pend(wr && bus_addr == OFF_PEND_B),
        .wr_isr(wr && bus_addr == OFF_ISR_B), .wr_mask(wr && bus_addr == OFF_MASK_B),
        .wdata(bus_wdata), .src(src_b), .iack_hit(iack ? hit_b : '0),
        .en(en_b), .pend(pend_b), .isr(isr_b), .mask(mask_b), .active(act_b));

    irq_prio #(.DW(DW)) u_prio (
        .act_a(act_a), .act_b(act_b), .any(irq), .code(irq_src),
        .hit_a(hit_a), .hit_b(hit_b));

    // Storage-only registers: vector, port edge and port direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_r  <= '0;
            edge_r <= '0;
            dir_r  <= '0;
        end else if (wr) begin
            if (bus_addr == OFF_VEC)  vec_r  <= bus_wdata;
            if (bus_addr == OFF_EDGE) edge_r <= bus_wdata;
            if (bus_addr == OFF_DIR)  dir_r  <= bus_wdata;
        end
    end

    // Read data mux; unmapped offsets return all ones.
    always_comb begin
        case (bus_addr)
            OFF_EN_A:   bus_rdata = en_a;
            OFF_EN_B:   bus_rdata = en_b;
            OFF_PEND_A: bus_rdata = pend_a;
            OFF_PEND_B: bus_rdata = pend_b;
            OFF_ISR_A:  bus_rdata = isr_a;
            OFF_ISR_B:  bus_rdata = isr_b;
            OFF_MASK_A: bus_rdata = mask_a;
            OFF_MASK_B: bus_rdata = mask_b;
            OFF_VEC:    bus_rdata = vec_r;
            OFF_EDGE:   bus_rdata = edge_r;
            OFF_DIR:    bus_rdata = dir_r;
            default:    bus_rdata = '1;
        endcase
    end

    assert_src_is_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_src[$clog2(DW)] ? (pend_a[irq_src[$clog2(DW)-1:0]] && mask_a[irq_src[$clog2(DW)-1:0]])
                                     : (pend_b[irq_src[$clog2(DW)-1:0]] && mask_b[irq_src[$clog2(DW)-1:0]])));
endmodule

// File: tb/tb_irq_reg_set.sv
module tb_irq_reg_set;
    localparam int WS = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_req = 1'b0, bus_wr = 1'b0, iack = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0, src_a = '0, src_b = '0;
    logic [7:0] bus_rdata;
    logic       bus_ack, irq;
    logic [3:0] irq_src;

    irq_reg_set #(.DW(8), .WAIT_STATES(WS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .src_a(src_a), .src_b(src_b), .iack(iack),
        .irq(irq), .irq_src(irq_src));

    always #2 clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit reset_phase = 1'b1;
    bit done = 1'b0;

    // Behavioural reference state.
    int m_en[2], m_pend[2], m_isr[2], m_mask[2];
    int m_vec, m_edge, m_dir, m_busy, m_cnt;

    function automatic int m_pick();
        for (int b = 0; b < 2; b++)
            for (int i = 7; i >= 0; i--)
                if (((m_pend[b] & m_mask[b]) >> i) & 1) return (b == 0) ? 8 + i : i;
        return -1;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return m_en[0];   1: return m_en[1];
            2: return m_pend[0]; 3: return m_pend[1];
            4: return m_isr[0];  5: return m_isr[1];
            6: return m_mask[0]; 7: return m_mask[1];
            8: return m_vec;     9: return m_edge;  10: return m_dir;
            default: return 255;
        endcase
    endfunction

    function automatic string req_of(int a);
        if (reset_phase) return "R1";
        if (a <= 1) return "R2";
        if (a <= 3) return "R3";
        if (a <= 5) return "R4";
        if (a <= 7) return "R5";
        if (a <= 10) return "R9";
        return "R8";
    endfunction

    // Reference model step at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 2; k++) begin
                m_en[k] = 0; m_pend[k] = 0; m_isr[k] = 0; m_mask[k] = 0;
            end
            m_vec = 0; m_edge = 0; m_dir = 0; m_busy = 0; m_cnt = 0;
        end else begin
            int ack, w, a, d, p;
            int hit[2];
            int srcv[2];
            ack = (m_busy != 0 && m_cnt == WS) ? 1 : 0;
            w = ack && bus_wr;
            a = int'(bus_addr); d = int'(bus_wdata);
            srcv[0] = int'(src_a); srcv[1] = int'(src_b);
            p = m_pick();
            hit[0] = 0; hit[1] = 0;
            if (iack && p >= 0) begin
                if (p >= 8) hit[0] = 1 << (p - 8); else hit[1] = 1 << p;
            end
            for (int k = 0; k < 2; k++) begin
                int en_n, keep;
                en_n = (w && a == k) ? d : m_en[k];
                keep = (w && (a == k || a == 2 + k)) ? d : 255;
                m_pend[k] = ((m_pend[k] & keep & ~hit[k]) | (srcv[k] & en_n)) & 255;
                m_isr[k] = (((w && a == 4 + k) ? (m_isr[k] & d) : m_isr[k]) | hit[k]) & 255;
                if (w && a == 6 + k) m_mask[k] = d;
                m_en[k] = en_n;
            end
            if (w && a == 8) m_vec = d;
            if (w && a == 9) m_edge = d;
            if (w && a == 10) m_dir = d;
            if (ack) m_busy = 0;
            else if (m_busy) m_cnt++;
            else if (bus_req) begin m_busy = 1; m_cnt = 0; end
        end
    end

    // Compare outputs with the model in the middle of the low phase.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            int e_ack, e_pick;
            e_ack = (m_busy != 0 && m_cnt == WS) ? 1 : 0;
            e_pick = m_pick();
            vectors++;
            if (int'(bus_ack) != e_ack) begin
                miscompares++;
                $display("FAIL R7 bus_ack actual=%0d expected=%0d", bus_ack, e_ack);
            end
            vectors++;
            if (int'(irq) != (e_pick >= 0 ? 1 : 0)) begin
                miscompares++;
                $display("FAIL %s irq actual=%0d expected=%0d", reset_phase ? "R1" : "R5",
                         irq, e_pick >= 0);
            end
            if (e_pick >= 0) begin
                vectors++;
                if (int'(irq_src) != e_pick) begin
                    miscompares++;
                    $display("FAIL R10 irq_src actual=%0d expected=%0d", irq_src, e_pick);
                end
            end
            if (e_ack && !bus_wr) begin
                vectors++;
                if (int'(bus_rdata) != m_read(int'(bus_addr))) begin
                    miscompares++;
                    $display("FAIL %s read off=%0d actual=%0h expected=%0h",
                             req_of(int'(bus_addr)), bus_addr, bus_rdata,
                             m_read(int'(bus_addr)));
                end
            end
        end
    end

    task automatic access(input bit wr, input int a, input int d);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = 4'(a); bus_wdata = 8'(d);
        do @(negedge clk); while (!bus_ack);
        bus_req = 1'b0;
    endtask

    task automatic pulse_src(input int a, input int b);
        @(negedge clk);
        src_a = 8'(a); src_b = 8'(b);
        @(negedge clk);
        src_a = '0; src_b = '0;
    endtask

    task automatic pulse_iack();
        @(negedge clk); iack = 1'b1;
        @(negedge clk); iack = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: every offset reads zero (or 0xFF where unmapped) after reset
        for (int a = 0; a < 16; a++) access(0, a, 0);
        reset_phase = 1'b0;
        // R2 R5: enables and masks
        access(1, 0, 8'hF0); access(1, 1, 8'hFF);
        access(1, 6, 8'hFF); access(1, 7, 8'h0F);
        // R6: only enabled sources latch
        pulse_src(8'hFF, 8'h81);
        access(0, 2, 0); access(0, 3, 0);
        // R3: zeros clear, ones ignored
        access(1, 2, 8'hBF); access(0, 2, 0);
        access(1, 3, 8'hFF); access(0, 3, 0);
        // R2: dropping enables drops pending
        access(1, 0, 8'h30); access(0, 2, 0);
        // R11 R10: acknowledge the two bank-A winners, then bank B
        pulse_iack(); pulse_iack(); pulse_iack();
        access(0, 4, 0); access(0, 5, 0); access(0, 3, 0);
        // R4: in-service clear by AND
        access(1, 4, 8'hDF); access(0, 4, 0);
        // R9: storage-only registers, no effect on irq
        access(1, 8, 8'h5A); access(1, 9, 8'hC3); access(1, 10, 8'h3C);
        access(0, 8, 0); access(0, 9, 0); access(0, 10, 0);
        // R8: unmapped offsets
        for (int a = 11; a < 16; a++) access(0, a, 0);
        // R6: set wins over a same-cycle clear of the same bit
        @(negedge clk); src_b = 8'h01;
        access(1, 3, 8'h00);
        @(negedge clk); src_b = 8'h00;
        access(0, 3, 0);
        // R6: enable written in the same cycle as the source pulse
        @(negedge clk); src_a = 8'h0C;
        access(1, 0, 8'h04);
        @(negedge clk); src_a = 8'h00;
        access(0, 2, 0);
        // Random mixed traffic across all requirements
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 3) pulse_src($urandom_range(0, 255), $urandom_range(0, 255));
            else if (r < 4) pulse_iack();
            else begin
                fork
                    access(r[0], $urandom_range(0, 15), $urandom_range(0, 255));
                    begin
                        repeat ($urandom_range(1, 4)) @(negedge clk);
                        src_a = 8'($urandom_range(0, 255)); src_b = 8'($urandom_range(0, 255));
                        iack = 1'($urandom_range(0, 1));
                        @(negedge clk);
                        src_a = '0; src_b = '0; iack = 1'b0;
                    end
                join
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule